// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block produces the feedback comparison pulse of a frequency synthesizer. It divides a fast input clock by a programmable ratio using a dual-modulus prescaler. A swallow count selects how many prescaler periods run at the long modulus M+1, and a main count sets how many prescaler periods make up one division. Every division is therefore (M+1)·A + M·(N−A) = M·N + A input clocks long. With the default 64/65 prescaler the output rate is f_in / (64·N + A).

The block samples the programmed swallow and main values only at a division boundary, so each division uses a single ratio from start to end. Settings that break the pulse-swallow rules are never used as given. The rules are: the main value must be at least 5, and it must be greater than the swallow value. A parameter selects how an illegal setting is handled. In clamp mode the main value is raised to the nearest legal value. In hold mode the last legal setting is kept. In both modes an error output is raised for the division that would have used the bad setting.

All logic runs in the input-clock domain and uses a synchronous, active-high reset. While reset is asserted, the block continuously loads the setting on its inputs.

Top module: `pswal_divider`

## Requirements
- R1: While `rst` is high, `fp` is low. If a legal setting is present during reset, `cfg_err` is low after release.
- R2: For a legal setting (N ≥ 5, N > A), consecutive `fp` pulses are exactly M·N + A input clocks apart, where M = 2^PRE_BITS (64 by default). This includes A = 0, which gives M·N.
- R3: After reset is released, the first `fp` pulse is high after the (M·N + A)-th rising clock edge, for the setting present during reset.
- R4: `fp` is high for exactly one input-clock cycle per division.
- R5: In clamp mode, a main value below MAIN_MIN (5) is replaced by max(MAIN_MIN, A+1), and `cfg_err` is high during that division.
- R6: In clamp mode, a main value N ≤ A (with N ≥ MAIN_MIN) is replaced by A+1, and `cfg_err` is high during that division.
- R7: `swallow_set` and `main_set` are sampled only at the clock edge where `fp` rises (or during reset). A change between two pulses does not affect the division in progress.
- R8: `cfg_err` is updated together with the sampled setting and is low while a legal setting is in use.
- R9: In hold mode, an illegal setting is rejected: the previous legal ratio keeps running and `cfg_err` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset; the setting is loaded while it is high |
| swallow_set | input | SWL_BITS (6) | Programmed swallow value A |
| main_set | input | MAIN_BITS (12) | Programmed main value N |
| fp | output | 1 | One-cycle pulse at the end of each division |
| cfg_err | output | 1 | High while the division in progress was requested with an illegal setting |

## Verification
Every internal state in this divider shows up as the spacing of `fp` pulses. A prescaler counter that slips, a swallow count that stops too early or too late, or a main count that is off by one each changes the next pulse gap by a predictable amount. Such an error is therefore visible within one division: at most M·(2^MAIN_BITS−1) + 2^SWL_BITS−1 clocks. A setting latched on the wrong edge shows up as a gap of the wrong length, either in the division that is running when the inputs change or in the division after it. A wrong legality decision shows up on `cfg_err` at the same boundary.

// File: rtl/pswal_pkg.sv
package pswal_pkg;

   // How a setting that violates the pulse-swallow rules is handled.
   typedef enum logic {
      POL_CLAMP = 1'b0,   // raise the main value to the nearest legal one
      POL_HOLD  = 1'b1    // keep the previous legal setting
   } pswal_policy_e;

endpackage

// File: rtl/pswal_cfg.sv
module pswal_cfg
   import pswal_pkg::*;
#(
   parameter int            A_W    = 6,
   parameter int            N_W    = 12,
   parameter int            N_LO   = 5,
   parameter pswal_policy_e POLICY = POL_CLAMP
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           load,
   input  logic [A_W-1:0] a_req,
   input  logic [N_W-1:0] n_req,
   output logic [A_W-1:0] a_act,
   output logic [N_W-1:0] n_act,
   output logic           bad_act
);

   localparam logic [N_W-1:0] N_LO_V = N_W'(N_LO);

   logic [N_W-1:0] a_ext;
   logic [N_W-1:0] a_plus;
   logic [N_W-1:0] n_floor;
   logic           bad_req;
   logic [A_W-1:0] a_nxt;
   logic [N_W-1:0] n_nxt;

   // The smallest legal main value for the requested swallow value.
   always_comb begin
      a_ext   = N_W'(a_req);
      a_plus  = a_ext + N_W'(1);
      n_floor = (a_plus > N_LO_V) ? a_plus : N_LO_V;
      bad_req = (n_req < n_floor);
   end

   generate
      if (POLICY == POL_CLAMP) begin : g_clamp
         always_comb begin
            a_nxt = a_req;
            n_nxt = bad_req ? n_floor : n_req;
         end
      end else begin : g_hold
         always_comb begin
            if (!bad_req) begin
               a_nxt = a_req;
               n_nxt = n_req;
            end else if (rst) begin
               a_nxt = '0;
               n_nxt = N_LO_V;
            end else begin
               a_nxt = a_act;
               n_nxt = n_act;
            end
         end

         // A rejected request leaves the running ratio untouched.
         assert_hold_rejects_R9 : assert property (@(posedge clk) disable iff (rst)
            (load && bad_req) |=> $stable({a_act, n_act}));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || load) begin
         a_act   <= a_nxt;
         n_act   <= n_nxt;
         bad_act <= bad_req;
      end
   end

   // The active setting only moves at a division boundary.
   assert_boundary_only_R7 : assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable({a_act, n_act, bad_act}));

   // Whatever was requested, the ratio in use obeys the swallow rules.
   assert_active_legal_R6 : assert property (@(posedge clk) disable iff (rst)
      (n_act >= N_LO_V) && (n_act > N_W'(a_act)));

endmodule

// File: rtl/pswal_prescaler.sv
module pswal_prescaler #(
   parameter int P_W = 6
) (
   input  logic clk,
   input  logic rst,
   input  logic alt,   // 1: divide by M+1, 0: divide by M
   output logic tc     // last input clock of a prescaler period
);

   localparam int            CW       = P_W + 1;
   localparam logic [CW-1:0] LAST_M   = CW'((1 << P_W) - 1);
   localparam logic [CW-1:0] LAST_ALT = CW'(1 << P_W);

   logic [CW-1:0] cnt;
   logic [CW-1:0] last;

   assign last = alt ? LAST_ALT : LAST_M;
   assign tc   = (cnt == last);

   always_ff @(posedge clk) begin
      if (rst || tc) cnt <= '0;
      else           cnt <= cnt + CW'(1);
   end

   // The modulus choice must not change inside a prescaler period.
   assert_mode_steady_R2 : assert property (@(posedge clk) disable iff (rst)
      (cnt != '0) |-> $stable(alt));

   // The extra count exists only in the long modulus.
   assert_long_only_R2 : assert property (@(posedge clk) disable iff (rst)
      (cnt == LAST_ALT) |-> alt);

endmodule

// File: rtl/pswal_seq.sv
module pswal_seq #(
   parameter int A_W = 6,
   parameter int N_W = 12
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           tc,
   input  logic [A_W-1:0] a_act,
   input  logic [N_W-1:0] n_act,
   output logic           alt,
   output logic           done
);

   logic [A_W-1:0] s_cnt;   // long prescaler periods completed
   logic [N_W-1:0] m_cnt;   // prescaler periods completed

   assign alt  = (s_cnt < a_act);
   assign done = tc && (m_cnt == (n_act - N_W'(1)));

   always_ff @(posedge clk) begin
      if (rst || done) begin
         s_cnt <= '0;
         m_cnt <= '0;
      end else if (tc) begin
         m_cnt <= m_cnt + N_W'(1);
         if (alt) s_cnt <= s_cnt + A_W'(1);
      end
   end

   // Every swallowed period is spent before the division closes (N > A).
   assert_swallow_spent_R2 : assert property (@(posedge clk) disable iff (rst)
      done |-> !alt);

   assert_main_range_R2 : assert property (@(posedge clk) disable iff (rst)
      m_cnt < n_act);

endmodule

// File: rtl/pswal_divider.sv
module pswal_divider
   import pswal_pkg::*;
#(
   parameter int            PRE_BITS  = 6,
   parameter int            SWL_BITS  = 6,
   parameter int            MAIN_BITS = 12,
   parameter int            MAIN_MIN  = 5,
   parameter pswal_policy_e POLICY    = POL_CLAMP
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [SWL_BITS-1:0]  swallow_set,
   input  logic [MAIN_BITS-1:0] main_set,
   output logic                 fp,
   output logic                 cfg_err
);

   generate
      if (PRE_BITS < 1) begin : g_bad_pre
         $error("PRE_BITS must be at least 1");
      end
      if (SWL_BITS < 1) begin : g_bad_swl
         $error("SWL_BITS must be at least 1");
      end
      if (MAIN_MIN < 2 || MAIN_MIN > (1 << MAIN_BITS) - 1) begin : g_bad_min
         $error("MAIN_MIN must lie in 2 .. 2**MAIN_BITS-1");
      end
      if ((1 << SWL_BITS) > (1 << MAIN_BITS) - 1) begin : g_bad_ratio
         $error("main counter too narrow to exceed every swallow value");
      end
   endgenerate

   logic [SWL_BITS-1:0]  a_act;
   logic [MAIN_BITS-1:0] n_act;
   logic                 alt;
   logic                 tc;
   logic                 done;

   pswal_cfg #(
      .A_W    (SWL_BITS),
      .N_W    (MAIN_BITS),
      .N_LO   (MAIN_MIN),
      .POLICY (POLICY)
   ) u_cfg (
      .clk     (clk),
      .rst     (rst),
      .load    (done),
      .a_req   (swallow_set),
      .n_req   (main_set),
      .a_act   (a_act),
      .n_act   (n_act),
      .bad_act (cfg_err)
   );

   pswal_prescaler #(
      .P_W (PRE_BITS)
   ) u_pre (
      .clk (clk),
      .rst (rst),
      .alt (alt),
      .tc  (tc)
   );

   pswal_seq #(
      .A_W (SWL_BITS),
      .N_W (MAIN_BITS)
   ) u_seq (
      .clk   (clk),
      .rst   (rst),
      .tc    (tc),
      .a_act (a_act),
      .n_act (n_act),
      .alt   (alt),
      .done  (done)
   );

   always_ff @(posedge clk) begin
      if (rst) fp <= 1'b0;
      else     fp <= done;
   end

   assert_fp_single_R4 : assert property (@(posedge clk) disable iff (rst)
      fp |=> !fp);

   assert_fp_follows_end_R3 : assert property (@(posedge clk) disable iff (rst)
      done |=> fp);

   assert_fp_low_in_reset_R1 : assert property (@(posedge clk)
      $past(rst) |-> !fp);

endmodule

// File: tb/sim_pswal_divider.sv
module sim_pswal_divider;
   import pswal_pkg::*;

   localparam int PB   = 3;
   localparam int AB   = 3;
   localparam int NB   = 4;
   localparam int NMIN = 5;
   localparam int M    = 1 << PB;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AB-1:0] a_in = '0;
   logic [NB-1:0] n_in = '0;
   logic          fp0, err0, fp1, err1;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   pswal_divider #(.PRE_BITS(PB), .SWL_BITS(AB), .MAIN_BITS(NB),
                   .MAIN_MIN(NMIN), .POLICY(POL_CLAMP)) u0 (
      .clk(clk), .rst(rst), .swallow_set(a_in), .main_set(n_in),
      .fp(fp0), .cfg_err(err0));

   pswal_divider #(.PRE_BITS(PB), .SWL_BITS(AB), .MAIN_BITS(NB),
                   .MAIN_MIN(NMIN), .POLICY(POL_HOLD)) u1 (
      .clk(clk), .rst(rst), .swallow_set(a_in), .main_set(n_in),
      .fp(fp1), .cfg_err(err1));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit illegal(input int a, input int n);
      return (n < NMIN) || (n <= a);
   endfunction

   function automatic int eff_n(input int a, input int n);
      int fl;
      fl = (a + 1 > NMIN) ? a + 1 : NMIN;
      return (n < fl) ? fl : n;
   endfunction

   // Counts falling edges until the selected fp is seen high.
   task automatic wait_pulse(input bit sel, output int span, output bit wide);
      span = 0;
      wide = 1'b0;
      do begin
         @(negedge clk);
         span++;
         if (span == 1 && (sel ? fp1 : fp0)) wide = 1'b1;
      end while (!(sel ? fp1 : fp0) && span < 1000);
      if (span >= 1000) check(1'b0, "watchdog-pulse", span, 0);
   endtask

   initial begin
      int  span;
      bit  wide;
      int  prev_l;
      a_in = 3'd3;
      n_in = 4'd5;
      rst  = 1'b1;
      repeat (3) @(negedge clk);
      check(fp0 == 1'b0, "R1 fp low in reset", fp0, 0);
      check(fp1 == 1'b0, "R1 fp low in reset (hold)", fp1, 0);
      rst = 1'b0;
      wait_pulse(1'b0, span, wide);
      check(span == M * 5 + 3, "R3 first pulse after reset", span, M * 5 + 3);
      check(err0 == 1'b0, "R1 err low for legal reset setting", err0, 0);
      prev_l = M * 5 + 3;

      // Sweep every swallow/main pair on the clamp-mode instance.
      for (int a = 0; a < (1 << AB); a++) begin
         for (int n = 0; n < (1 << NB); n++) begin
            int    exp_l;
            bit    bad;
            string tag;
            a_in  = AB'(a);
            n_in  = NB'(n);
            bad   = illegal(a, n);
            exp_l = M * eff_n(a, n) + a;
            tag   = !bad ? "R2" : (n < NMIN ? "R5" : "R6");
            wait_pulse(1'b0, span, wide);
            check(span == prev_l, "R7 change mid-division ignored", span, prev_l);
            check(!wide, "R4 pulse width", wide, 0);
            check(err0 == bad, bad ? tag : "R8", err0, bad);
            wait_pulse(1'b0, span, wide);
            check(span == exp_l, tag, span, exp_l);
            check(!wide, "R4 pulse width", wide, 0);
            prev_l = exp_l;
         end
      end

      // Hold-mode instance: legal baseline, then an illegal request.
      a_in = 3'd2;
      n_in = 4'd6;
      wait_pulse(1'b1, span, wide);
      wait_pulse(1'b1, span, wide);
      check(span == M * 6 + 2, "R2 hold-mode legal ratio", span, M * 6 + 2);
      check(err1 == 1'b0, "R8 hold-mode err low", err1, 0);
      a_in = 3'd5;
      n_in = 4'd3;
      wait_pulse(1'b1, span, wide);
      check(span == M * 6 + 2, "R7 hold-mode boundary", span, M * 6 + 2);
      check(err1 == 1'b1, "R9 err on rejected setting", err1, 1);
      wait_pulse(1'b1, span, wide);
      check(span == M * 6 + 2, "R9 previous ratio kept", span, M * 6 + 2);
      check(!wide, "R4 hold-mode pulse width", wide, 0);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule